// File: doc/BRIEF.md
# Fully Associative Translation Cache with Invalidation

This block holds recently used translations from virtual page number to page table entry. Every entry is compared with the requested page number at once, and the answer comes back in the same cycle as the request. On a hit the block returns the whole cached entry and builds the physical address from the entry's frame field and the untouched page offset. On a miss it raises a miss flag, so the refill source (a hardware walker or a software loader) can fetch the entry and write it back through the fill port.

Software keeps the cache consistent with the page tables in two ways. It can drop the one entry whose page number matches a given number, for example after that page's protection changes. It can also clear every entry at once when the address space changes. When the cache is full, a fill replaces an entry picked by a rotating pointer. The pointer skips the entry used most recently.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits until a fill has been written.
- R2: When `lk_valid` is high, `hit` rises in the same cycle if a valid entry's tag equals `lk_vpn`. Otherwise `miss` rises. Both stay low while `lk_valid` is low.
- R3: On a hit, `hit_pte` is the cached entry and `phys_addr` is `{hit_pte[FRAME_LSB+FRAME_W-1:FRAME_LSB], lk_ofs}`. The defaults are FRAME_LSB=12, FRAME_W=20 and OFS_W=12.
- R4: The cache holds ENTRIES translations at once. ENTRIES must lie between 16 and 48, and elaboration stops otherwise.
- R5: A fill whose page number is already cached overwrites that entry and does not make a second copy.
- R6: A fill for a new page number goes to the lowest-index invalid entry when one exists.
- R7: With no invalid entry, the victim is the rotating pointer's entry, or the next index if the pointer equals the most recently used index. The pointer then moves to one past the victim. The pointer and the used index both reset to 0. The used index follows every hit and every fill, and a fill wins when both happen in one cycle.
- R8: `inv_en` clears the valid entry whose tag equals `inv_vpn`. A lookup of that same page number in the same cycle reports a miss.
- R9: `flush` clears every entry, and every lookup in the same cycle reports a miss.
- R10: Requests in one cycle take effect in the order flush, then invalidate, then fill. A fill therefore survives a flush or an invalidate of its own page number in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_ofs | input | OFS_W | Page offset of the request |
| hit | output | 1 | Lookup found a valid entry |
| miss | output | 1 | Lookup found nothing; refill needed |
| hit_pte | output | PTE_W | Cached entry on a hit, zero otherwise |
| phys_addr | output | FRAME_W+OFS_W | Frame joined with offset |
| fill_en | input | 1 | Refill write |
| fill_vpn | input | VPN_W | Page number being filled |
| fill_pte | input | PTE_W | Entry being filled |
| inv_en | input | 1 | Invalidate one page number |
| inv_vpn | input | VPN_W | Page number to invalidate |
| flush | input | 1 | Clear every entry |

## Verification
The bench aims at the cases where the victim rule can go wrong. A fill while the rotating pointer sits on the most recently used entry must move to the next entry; a design without the skip would throw out the entry just used. A refill of a page number already cached must overwrite it; a design that got this wrong would leave two matching tags and return an OR of two entries. The bench also drives lookups in the same cycle as a flush or a matching invalidate, and a broken design would hit on stale data. It drives fills in the same cycle as a flush or an invalidate of the same page number, and a broken design would lose the new entry.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [1:0] {
      FILL_NONE,
      FILL_SAME,
      FILL_FREE,
      FILL_EVICT
   } fill_kind_e;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/xlat_entry.sv
module xlat_entry #(
   parameter int unsigned VPN_W = 20,
   parameter int unsigned PTE_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic             flush,
   input  logic             inv_en,
   input  logic [VPN_W-1:0] inv_vpn,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PTE_W-1:0] fill_pte,
   input  logic             wr_en,
   output logic             lk_match,
   output logic             fill_match,
   output logic             free,
   output logic [PTE_W-1:0] pte_o
);

   logic             valid_q;
   logic [VPN_W-1:0] tag_q;
   logic [PTE_W-1:0] pte_q;
   logic             live;

   always_comb begin
      lk_match   = valid_q && (tag_q == lk_vpn);
      live       = valid_q && !flush && !(inv_en && (tag_q == inv_vpn));
      fill_match = live && (tag_q == fill_vpn);
      free       = !live;
      pte_o      = pte_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tag_q   <= '0;
         pte_q   <= '0;
      end else if (wr_en) begin
         valid_q <= 1'b1;
         tag_q   <= fill_vpn;
         pte_q   <= fill_pte;
      end else begin
         valid_q <= live;
      end
   end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
   import xlat_pkg::*;
#(
   parameter int unsigned N        = 16,
   parameter bit          SKIP_MRU = 1'b1,
   localparam int unsigned IW      = idx_w(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fill_en,
   input  logic [N-1:0]  fill_match,
   input  logic [N-1:0]  free,
   input  logic          hit_upd,
   input  logic [IW-1:0] hit_idx,
   output logic [IW-1:0] wr_idx
);

   localparam logic [IW-1:0] LAST = IW'(N - 1);

   logic [IW-1:0] rr_q, mru_q, cand, match_idx, free_idx;
   logic          match_any, free_any;
   fill_kind_e    kind;

   function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] x);
      return (x == LAST) ? '0 : x + 1'b1;
   endfunction

   always_comb begin
      match_any = 1'b0;
      match_idx = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (fill_match[i]) begin
            match_any = 1'b1;
            match_idx = IW'(i);
         end
      end
   end

   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = int'(N) - 1; i >= 0; i--) begin
         if (free[i]) begin
            free_any = 1'b1;
            free_idx = IW'(i);
         end
      end
   end

   generate
      if (SKIP_MRU) begin : g_nlu
         always_comb cand = (rr_q == mru_q) ? wrap_inc(rr_q) : rr_q;
      end else begin : g_rr
         always_comb cand = rr_q;
      end
   endgenerate

   always_comb begin
      if (!fill_en) begin
         kind   = FILL_NONE;
         wr_idx = '0;
      end else if (match_any) begin
         kind   = FILL_SAME;
         wr_idx = match_idx;
      end else if (free_any) begin
         kind   = FILL_FREE;
         wr_idx = free_idx;
      end else begin
         kind   = FILL_EVICT;
         wr_idx = cand;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_q  <= '0;
         mru_q <= '0;
      end else begin
         if (kind == FILL_EVICT) rr_q <= wrap_inc(cand);
         if (kind != FILL_NONE)  mru_q <= wr_idx;
         else if (hit_upd)       mru_q <= hit_idx;
      end
   end

endmodule

// File: rtl/xlat_pte_sel.sv
module xlat_pte_sel #(
   parameter int unsigned N     = 16,
   parameter int unsigned PTE_W = 32,
   parameter int unsigned IW    = 4
) (
   input  logic [N-1:0]       hit_vec,
   input  logic [N*PTE_W-1:0] pte_flat,
   output logic               any,
   output logic [IW-1:0]      idx,
   output logic [PTE_W-1:0]   pte
);

   always_comb begin
      any = |hit_vec;
      idx = '0;
      pte = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (hit_vec[i]) begin
            idx = idx | IW'(i);
            pte = pte | pte_flat[i*PTE_W +: PTE_W];
         end
      end
   end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int unsigned ENTRIES   = 16,
   parameter int unsigned VPN_W     = 20,
   parameter int unsigned OFS_W     = 12,
   parameter int unsigned PTE_W     = 32,
   parameter int unsigned FRAME_W   = 20,
   parameter int unsigned FRAME_LSB = 12,
   parameter bit          SKIP_MRU  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     lk_valid,
   input  logic [VPN_W-1:0]         lk_vpn,
   input  logic [OFS_W-1:0]         lk_ofs,
   output logic                     hit,
   output logic                     miss,
   output logic [PTE_W-1:0]         hit_pte,
   output logic [FRAME_W+OFS_W-1:0] phys_addr,
   input  logic                     fill_en,
   input  logic [VPN_W-1:0]         fill_vpn,
   input  logic [PTE_W-1:0]         fill_pte,
   input  logic                     inv_en,
   input  logic [VPN_W-1:0]         inv_vpn,
   input  logic                     flush
);

   localparam int unsigned IW = idx_w(ENTRIES);

   if (ENTRIES < 16 || ENTRIES > 48) begin : g_bad_entries
      $error("xlat_cache: ENTRIES must be within 16..48");
   end
   if (FRAME_LSB + FRAME_W > PTE_W) begin : g_bad_frame
      $error("xlat_cache: frame field exceeds PTE width");
   end

   logic [ENTRIES-1:0]       raw_match, fill_match, free, wr_en, hit_vec;
   logic [ENTRIES*PTE_W-1:0] pte_flat;
   logic [IW-1:0]            wr_idx, hit_idx;
   logic                     lk_block;

   for (genvar i = 0; i < int'(ENTRIES); i++) begin : g_ent
      assign wr_en[i] = fill_en && (wr_idx == IW'(i));
      xlat_entry #(.VPN_W(VPN_W), .PTE_W(PTE_W)) u_ent (
         .clk        (clk),
         .rst_n      (rst_n),
         .lk_vpn     (lk_vpn),
         .flush      (flush),
         .inv_en     (inv_en),
         .inv_vpn    (inv_vpn),
         .fill_vpn   (fill_vpn),
         .fill_pte   (fill_pte),
         .wr_en      (wr_en[i]),
         .lk_match   (raw_match[i]),
         .fill_match (fill_match[i]),
         .free       (free[i]),
         .pte_o      (pte_flat[i*PTE_W +: PTE_W])
      );
   end

   always_comb begin
      lk_block = flush || (inv_en && (inv_vpn == lk_vpn));
      hit_vec  = (lk_valid && !lk_block) ? raw_match : '0;
   end

   xlat_pte_sel #(.N(ENTRIES), .PTE_W(PTE_W), .IW(IW)) u_sel (
      .hit_vec  (hit_vec),
      .pte_flat (pte_flat),
      .any      (hit),
      .idx      (hit_idx),
      .pte      (hit_pte)
   );

   xlat_victim #(.N(ENTRIES), .SKIP_MRU(SKIP_MRU)) u_vic (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_en    (fill_en),
      .fill_match (fill_match),
      .free       (free),
      .hit_upd    (hit),
      .hit_idx    (hit_idx),
      .wr_idx     (wr_idx)
   );

   assign miss      = lk_valid && !hit;
   assign phys_addr = {hit_pte[FRAME_LSB +: FRAME_W], lk_ofs};

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned OFS_W   = 12,
   parameter int unsigned FRAME_W = 20
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     lk_valid,
   input logic [VPN_W-1:0]         lk_vpn,
   input logic [OFS_W-1:0]         lk_ofs,
   input logic                     hit,
   input logic                     miss,
   input logic [FRAME_W+OFS_W-1:0] phys_addr,
   input logic                     fill_en,
   input logic [VPN_W-1:0]         fill_vpn,
   input logic                     inv_en,
   input logic [VPN_W-1:0]         inv_vpn,
   input logic                     flush
);

   // R2
   hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> lk_valid && !miss);

   // R3
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> phys_addr[OFS_W-1:0] == lk_ofs);

   // R9
   flush_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !hit);

   // R9
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush && !fill_en |=> !hit);

   // R8
   inv_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_en && lk_valid && lk_vpn == inv_vpn |-> !hit);

   // R8
   inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_en && !(fill_en && fill_vpn == inv_vpn)
      |=> !(hit && lk_vpn == $past(inv_vpn)));

   // R10
   fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> !(lk_valid && lk_vpn == $past(fill_vpn) && !flush
                    && !(inv_en && inv_vpn == lk_vpn)) || hit);

endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .OFS_W(OFS_W), .FRAME_W(FRAME_W)) u_chk (.*);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;

   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [19:0] lk_vpn = '0;
   logic [11:0] lk_ofs = '0;
   logic        hit, miss;
   logic [31:0] hit_pte;
   logic [31:0] phys_addr;
   logic        fill_en = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [31:0] fill_pte = '0;
   logic        inv_en = 1'b0;
   logic [19:0] inv_vpn = '0;
   logic        flush = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   bit          m_val [N];
   logic [19:0] m_vpn [N];
   logic [31:0] m_pte [N];
   int          m_rr, m_mru;

   always #4 clk = ~clk;

   xlat_cache u_dut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
      .lk_ofs(lk_ofs), .hit(hit), .miss(miss), .hit_pte(hit_pte),
      .phys_addr(phys_addr), .fill_en(fill_en), .fill_vpn(fill_vpn),
      .fill_pte(fill_pte), .inv_en(inv_en), .inv_vpn(inv_vpn), .flush(flush)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int find(input logic [19:0] v);
      for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == v) return i;
      return -1;
   endfunction

   task automatic compare();
      int  k;
      bit  eh;
      k  = find(lk_vpn);
      eh = lk_valid && !flush && !(inv_en && inv_vpn == lk_vpn) && (k >= 0);
      check(hit == eh, (cur_req == "R1") ? "R1" : cur_req, "hit", hit, eh);
      check(miss == (lk_valid && !eh), "R2", "miss", miss, lk_valid && !eh);
      if (eh) begin
         check(hit_pte == m_pte[k], "R3", "pte", hit_pte, m_pte[k]);
         check(phys_addr == {m_pte[k][31:12], lk_ofs}, "R3", "phys",
               phys_addr, {m_pte[k][31:12], lk_ofs});
      end
   endtask

   task automatic model_step();
      int  k, w;
      bit  eh;
      k  = find(lk_vpn);
      eh = lk_valid && !flush && !(inv_en && inv_vpn == lk_vpn) && (k >= 0);
      if (flush) for (int i = 0; i < N; i++) m_val[i] = 1'b0;
      if (inv_en) begin
         w = find(inv_vpn);
         if (w >= 0) m_val[w] = 1'b0;
      end
      if (fill_en) begin
         w = find(fill_vpn);
         if (w < 0)
            for (int i = N - 1; i >= 0; i--) if (!m_val[i]) w = i;
         if (w < 0) begin
            w = (m_rr == m_mru) ? (m_rr + 1) % N : m_rr;
            m_rr = (w + 1) % N;
         end
         m_val[w] = 1'b1;
         m_vpn[w] = fill_vpn;
         m_pte[w] = fill_pte;
         m_mru = w;
      end else if (eh) begin
         m_mru = k;
      end
   endtask

   task automatic tick();
      #1;
      if (rst_n) compare();
      @(posedge clk);
      if (rst_n) model_step();
      @(negedge clk);
   endtask

   task automatic cyc(input bit lv, input logic [19:0] lvpn,
                      input bit fe, input logic [19:0] fvpn, input logic [31:0] fpte,
                      input bit ie, input logic [19:0] ivpn, input bit fl);
      lk_valid = lv; lk_vpn = lvpn; lk_ofs = 12'($urandom);
      fill_en = fe; fill_vpn = fvpn; fill_pte = fpte;
      inv_en = ie; inv_vpn = ivpn; flush = fl;
      tick();
   endtask

   task automatic look(input logic [19:0] v);
      cyc(1, v, 0, '0, '0, 0, '0, 0);
   endtask

   task automatic fill(input logic [19:0] v, input logic [31:0] p);
      cyc(0, '0, 1, v, p, 0, '0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_val[i] = 1'b0; m_vpn[i] = '0; m_pte[i] = '0;
      end
      m_rr = 0; m_mru = 0;
      @(negedge clk);
      repeat (4) tick();
      rst_n = 1'b1;

      // R1: nothing hits after reset
      cur_req = "R1";
      look(20'h0); look(20'h5); look(20'h101);

      // R6 / R4: fill into free entries, then every one must hit
      cur_req = "R6";
      for (int i = 0; i < N; i++) fill(20'h100 + 20'(i), {20'h8000 + 20'(i), 12'h0a5});
      cur_req = "R4";
      for (int i = 0; i < N; i++) look(20'h100 + 20'(i));

      // R5: refill of a cached page overwrites in place
      cur_req = "R5";
      fill(20'h105, 32'hdead_b007);
      for (int i = 0; i < N; i++) look(20'h100 + 20'(i));

      // R7: eviction with the pointer on the used entry and elsewhere
      cur_req = "R7";
      look(20'h100);
      fill(20'h200, 32'h1111_1000);
      look(20'h101);
      fill(20'h201, 32'h2222_2000);
      fill(20'h202, 32'h3333_3000);
      for (int i = 0; i < N; i++) look(20'h100 + 20'(i));
      look(20'h200); look(20'h201); look(20'h202);

      // R8: invalidate with a same-cycle lookup of that page
      cur_req = "R8";
      cyc(1, 20'h107, 0, '0, '0, 1, 20'h107, 0);
      look(20'h107); look(20'h108);
      cyc(1, 20'h109, 0, '0, '0, 1, 20'h555, 0);

      // R10: same-cycle invalidate and fill of one page
      cur_req = "R10";
      cyc(1, 20'h108, 1, 20'h108, 32'h4444_4000, 1, 20'h108, 0);
      look(20'h108);

      // R9: flush with a lookup in the same cycle
      cur_req = "R9";
      cyc(1, 20'h109, 0, '0, '0, 0, '0, 1);
      look(20'h109); look(20'h10a);

      // R10: fill survives a flush in the same cycle
      cur_req = "R10";
      fill(20'h10b, 32'h5555_5000);
      cyc(1, 20'h10b, 1, 20'h300, 32'h6666_6000, 0, '0, 1);
      look(20'h300); look(20'h10b);

      // R2 / R3: mixed traffic over a small page pool
      cur_req = "R2";
      for (int c = 0; c < 4000; c++) begin
         cyc(($urandom % 5) != 0, 20'($urandom % 40),
             ($urandom % 4) == 0, 20'($urandom % 40), $urandom,
             ($urandom % 20) == 0, 20'($urandom % 40),
             ($urandom % 100) == 0);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule